// File: doc/BRIEF.md
# Dual-Convention Host Bus Slave Front End

This block lets an external microprocessor read and write a small bank of 8-bit registers over an asynchronous parallel bus. A strap input picks which strobe convention the host uses. In the first, one data strobe is qualified by a read/not-write level. In the second, there is a separate active-low read strobe and a separate active-low write strobe, both carried on the same two pins. A second strap picks whether the address arrives on its own pins or is time-shared with the data bus and marked by an address latch pulse.

All host control pins pass through two-flop synchronizers into the core clock, so every access is seen three core clocks after its pin edge. While a read is open, the block enables its data output drivers. The data pad itself is represented by a data output and an output-enable pin. When a write strobe ends, the block commits the last data it sampled. It raises a one-clock write strobe toward the register bank and updates the addressed configuration register.

The 22 implemented registers are laid out as follows. Three read-only status bytes come from a status input. Nineteen read/write configuration bytes are driven out in parallel. The rest of the 5-bit address space reads as zero.

Top module: `hbus_front`

## Requirements
- R1: While reset is low and after it, with no access, `dq_oe` and `wr_stb` are 0 and every configuration byte is 0x00.
- R2: With `sel_rdwr`=0, a read is open while `cs_n`=0, `ds_n`=0 and `rw_n`=1. During it `dq_oe`=1 and `dq_out` carries the addressed register.
- R3: With `sel_rdwr`=0, `cs_n`=0, `ds_n`=0 and `rw_n`=0 form a write. It commits when that condition ends, normally on the rising `ds_n` edge, and `cs_n` may rise together with `ds_n`.
- R4: With `sel_rdwr`=1, `rw_n` acts as the active-low read strobe and `ds_n` as the active-low write strobe. Read needs read low and write high. Write needs write low and read high. Both low together is neither a read nor a write.
- R5: With `sel_mux`=0, the address is taken from `addr` at the start of each access, and `alat` has no effect.
- R6: With `sel_mux`=1, the address is taken from `dq_in[4:0]` when a falling `alat` edge is detected, and `addr` has no effect.
- R7: With `cs_n`=1, no strobe pattern opens a read or commits a write.
- R8: Addresses 0..2 read status byte k from `stat_in[8k+7:8k]`. Writes to them are ignored and raise no `wr_stb`.
- R9: Addresses 22..31 read 0x00. Writes to them are ignored and raise no `wr_stb`.
- R10: `dq_out` is 0x00 whenever `dq_oe` is 0, and `dq_oe` is never 1 in the cycle `wr_stb` is 1.
- R11: Each committed write to a configuration address (3..21) gives exactly one one-cycle `wr_stb`, with `wr_addr` and `wr_data` valid. The register then holds `wr_data`.
- R12: `dq_oe` rises in the third core clock after the read strobe edge. `wr_stb` is high in the second cycle after the write strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| sel_rdwr | input | 1 | Strap: 0 data strobe + read/write level, 1 separate read/write strobes |
| sel_mux | input | 1 | Strap: 0 separate address pins, 1 address shared with data |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe (style 0) or write strobe (style 1) |
| rw_n | input | 1 | Read/not-write level (style 0) or read strobe (style 1) |
| alat | input | 1 | Address latch; falling edge captures the shared address |
| addr | input | 5 | Separate address pins |
| dq_in | input | 8 | Data bus as seen by the block |
| dq_out | output | 8 | Read data toward the bus pad |
| dq_oe | output | 1 | Bus pad output enable |
| stat_in | input | 24 | Three read-only status bytes |
| cfg_out | output | 152 | Nineteen configuration bytes, register 3 in the low byte |
| wr_stb | output | 1 | One-cycle write strobe into the register bank |
| wr_addr | output | 5 | Address of the committed write |
| wr_data | output | 8 | Data of the committed write |

## Verification
The bench drives each strobe convention in both address modes. It goes after the cases a careless decode would get wrong. One is both strobes low in the separate-strobe style: a decoder that checks only one strobe would write or drive the bus there. Another is chip select rising together with the data strobe: a design that tests select at the trailing edge would drop the write. The bench also drives junk on whichever address source is inactive and toggles the latch pulse in separate-address mode, so that a decoder listening to the wrong source returns the wrong register. Writes aimed at status or unimplemented addresses must leave the bank and the strobe quiet, and reads there must return status or zero rather than stale configuration data.

// File: rtl/hbus_front.sv
module hbus_front #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int NREG  = 22,
  parameter int NSTAT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_rdwr,
  input  logic                       sel_mux,
  input  logic                       cs_n,
  input  logic                       ds_n,
  input  logic                       rw_n,
  input  logic                       alat,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              dq_in,
  output logic [DW-1:0]              dq_out,
  output logic                       dq_oe,
  input  logic [NSTAT*DW-1:0]        stat_in,
  output logic [(NREG-NSTAT)*DW-1:0] cfg_out,
  output logic                       wr_stb,
  output logic [AW-1:0]              wr_addr,
  output logic [DW-1:0]              wr_data
);
  localparam int NCFG = NREG - NSTAT;
  localparam int CW   = (NCFG  > 1) ? $clog2(NCFG)  : 1;
  localparam int SW   = (NSTAT > 1) ? $clog2(NSTAT) : 1;

  logic [3:0]    s1, s2;
  logic          rd_act, wr_act, al_prev;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdata;
  logic [DW-1:0] cfg    [NCFG];
  logic [DW-1:0] stat_b [NSTAT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= {cs_n, ds_n, rw_n, alat};
      s2 <= s1;
    end

  wire cs_s = s2[3];
  wire ds_s = s2[2];
  wire rw_s = s2[1];
  wire al_s = s2[0];

  wire rd_lvl = !cs_s && (sel_rdwr ? (!rw_s && ds_s) : (!ds_s && rw_s));
  wire wr_lvl = !cs_s && !ds_s && (sel_rdwr ? rw_s : !rw_s);
  wire commit = wr_act && !wr_lvl;
  wire in_cfg = (addr_q >= AW'(NSTAT)) && (addr_q < AW'(NREG));
  wire [CW-1:0] cidx = CW'(addr_q - AW'(NSTAT));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_act  <= 1'b0;
      wr_act  <= 1'b0;
      al_prev <= 1'b1;
      addr_q  <= '0;
      wdat_q  <= '0;
    end else begin
      rd_act  <= rd_lvl;
      wr_act  <= wr_lvl;
      al_prev <= al_s;
      if (sel_mux) begin
        if (al_prev && !al_s) addr_q <= dq_in[AW-1:0];
      end else if ((rd_lvl && !rd_act) || (wr_lvl && !wr_act)) begin
        addr_q <= addr;
      end
      if (wr_lvl) wdat_q <= dq_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) cfg[i] <= '0;
    end else if (commit && in_cfg) begin
      cfg[cidx] <= wdat_q;
    end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    assign cfg_out[g*DW +: DW] = cfg[g];
  end
  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    assign stat_b[g] = stat_in[g*DW +: DW];
  end

  always_comb begin
    rdata = '0;
    if (addr_q < AW'(NSTAT)) rdata = stat_b[SW'(addr_q)];
    else if (in_cfg)         rdata = cfg[cidx];
  end

  assign dq_oe   = rd_act;
  assign dq_out  = rd_act ? rdata : '0;
  assign wr_stb  = commit && in_cfg;
  assign wr_addr = addr_q;
  assign wr_data = wdat_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);                                          // R11
  AST_NO_OE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && wr_stb));                                          // R10
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0);                                     // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg_out));                                // R8
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && addr_q >= AW'(NREG)) |-> dq_out == '0);             // R9
endmodule

// File: tb/sim_hbus_front.sv
module sim_hbus_front;
  localparam int AW = 5, DW = 8, NREG = 22, NSTAT = 3, NCFG = NREG - NSTAT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_rdwr = 1'b0, sel_mux = 1'b0;
  logic cs_n = 1'b1, ds_n = 1'b1, rw_n = 1'b1, alat = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [NSTAT*DW-1:0] stat_in = 24'hA5_3C_81;
  logic [DW-1:0] dq_out, wr_data;
  logic [AW-1:0] wr_addr;
  logic dq_oe, wr_stb;
  logic [NCFG*DW-1:0] cfg_out;

  always #10 clk = ~clk;

  hbus_front u0 (.clk(clk), .rst_n(rst_n), .sel_rdwr(sel_rdwr), .sel_mux(sel_mux),
    .cs_n(cs_n), .ds_n(ds_n), .rw_n(rw_n), .alat(alat), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .stat_in(stat_in), .cfg_out(cfg_out),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_reg [32];
  int   m_addr, m_wdat;
  bit   m_rd, m_wr, m_alp;
  logic [3:0] hist [$];   // {cs,ds,rw,al}, newest first

  function automatic bit is_rd(logic [3:0] p);
    if (p[3]) return 0;
    return sel_rdwr ? (!p[1] && p[2]) : (!p[2] && p[1]);
  endfunction
  function automatic bit is_wr(logic [3:0] p);
    if (p[3] || p[2]) return 0;
    return sel_rdwr ? p[1] : !p[1];
  endfunction
  function automatic bit wrable(int a);
    return a >= NSTAT && a < NREG;
  endfunction
  function automatic int rdv(int a);
    if (a < NSTAT) return int'(stat_in[a*DW +: DW]);
    if (a < NREG)  return m_reg[a];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_addr = 0; m_wdat = 0; m_rd = 0; m_wr = 0; m_alp = 1;
      hist = {4'hF, 4'hF, 4'hF};
    end else begin
      bit rl, wl, al;
      rl = is_rd(hist[1]); wl = is_wr(hist[1]); al = hist[1][0];
      if (m_wr && !wl && wrable(m_addr)) m_reg[m_addr] = m_wdat;
      if (sel_mux) begin
        if (m_alp && !al) m_addr = int'(dq_in[AW-1:0]);
      end else if ((rl && !m_rd) || (wl && !m_wr)) m_addr = int'(addr);
      if (wl) m_wdat = int'(dq_in);
      m_rd = rl; m_wr = wl; m_alp = al;
      hist.push_front({cs_n, ds_n, rw_n, alat});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && hist.size() == 3) begin
      bit es;
      es = m_wr && !is_wr(hist[1]) && wrable(m_addr);
      chk("R2/R4 model dq_oe", dq_oe, m_rd);
      chk("R10 model dq_out", dq_out, m_rd ? rdv(m_addr) : 0);
      chk("R11 model wr_stb", wr_stb, es);
      if (es) begin
        chk("R11 model wr_addr", wr_addr, m_addr);
        chk("R11 model wr_data", wr_data, m_wdat);
      end
      for (int i = 0; i < NCFG; i++)
        if (int'(cfg_out[i*DW +: DW]) != m_reg[i+NSTAT])
          chk("R3 model cfg byte", cfg_out[i*DW +: DW], m_reg[i+NSTAT]);
    end
  end

  // ---------------- directed stimulus ----------------
  int sh [32];

  task automatic access(bit rdwr, bit mux, bit wr, int a, int d, bit csel, output int rv);
    @(negedge clk);
    sel_rdwr = rdwr; sel_mux = mux;
    addr = mux ? 5'h1F : AW'(a);
    if (mux) begin
      dq_in = DW'(a); alat = 1; step(2); alat = 0; step(4);
    end
    dq_in = wr ? DW'(d) : '0;
    if (!rdwr) begin
      rw_n = !wr; step(1); cs_n = !csel; ds_n = 0;
    end else begin
      cs_n = !csel;
      if (wr) ds_n = 0; else rw_n = 0;
    end
    if (!wr && csel) begin
      step(2); chk("R12 oe not yet", dq_oe, 0);
      step(1); chk("R12 oe third clock", dq_oe, 1);
      step(5);
    end else begin
      step(8);
      chk("R10 no drive on write", dq_oe, 0);
    end
    rv = int'(dq_out);
    cs_n = 1; ds_n = 1; rw_n = 1;
    if (wr && csel && wrable(a)) begin
      step(2); chk("R12 wr_stb second cycle", wr_stb, 1);
      step(1); chk("R11 wr_stb one cycle", wr_stb, 0);
      step(2);
      sh[a] = d;
    end else step(5);
    dq_in = '0; alat = 1; addr = '0; step(3);
  endtask

  task automatic expect_rd(string tag, bit rdwr, bit mux, int a, int exp);
    int rv;
    access(rdwr, mux, 0, a, 0, 1, rv);
    chk(tag, rv, exp);
  endtask

  task automatic wr(bit rdwr, bit mux, int a, int d);
    int rv;
    access(rdwr, mux, 1, a, d, 1, rv);
  endtask

  initial begin
    int rv;
    foreach (sh[i]) sh[i] = 0;
    step(4);
    chk("R1 reset oe", dq_oe, 0);
    chk("R1 reset stb", wr_stb, 0);
    chk("R1 reset cfg", cfg_out == '0, 1);
    @(negedge clk) rst_n = 1;
    step(3);
    chk("R1 idle oe", dq_oe, 0);

    // R2 R3 R5: data strobe style, separate address
    wr(0, 0, 3, 8'h11); wr(0, 0, 21, 8'h5A); wr(0, 0, 10, 8'hC3);
    expect_rd("R2 read reg3", 0, 0, 3, 8'h11);
    expect_rd("R3 read reg21", 0, 0, 21, 8'h5A);
    expect_rd("R2 read reg10", 0, 0, 10, 8'hC3);
    fork
      expect_rd("R5 latch pulse ignored", 0, 0, 10, 8'hC3);
      begin step(6); alat = 0; dq_in = 8'h03; step(2); alat = 1; dq_in = '0; end
    join
    // R8 status, R9 unimplemented
    wr(0, 0, 1, 8'hEE);
    expect_rd("R8 status kept", 0, 0, 1, 8'h3C);
    expect_rd("R8 status0", 0, 0, 0, 8'h81);
    wr(0, 0, 25, 8'h66);
    expect_rd("R9 unimpl zero", 0, 0, 25, 0);
    // R7 chip select high
    access(0, 0, 1, 4, 8'h99, 0, rv);
    expect_rd("R7 no write without select", 0, 0, 4, 0);
    access(0, 0, 0, 3, 0, 0, rv);
    chk("R7 no read without select", rv, 0);
    // R4 separate read/write strobes
    wr(1, 0, 5, 8'h77);
    expect_rd("R4 rd/wr readback", 1, 0, 5, 8'h77);
    @(negedge clk);
    sel_rdwr = 1; addr = 5'd6; dq_in = 8'hAB; cs_n = 0; rw_n = 0; ds_n = 0;
    step(8);
    chk("R4 both low no drive", dq_oe, 0);
    cs_n = 1; rw_n = 1; ds_n = 1; step(5);
    chk("R4 both low no strobe", wr_stb, 0);
    dq_in = '0; step(2);
    expect_rd("R4 both low no write", 1, 0, 6, 0);
    // R6 shared address bus, both styles
    wr(1, 1, 7, 8'h99);
    expect_rd("R6 mux rd/wr style", 1, 1, 7, 8'h99);
    wr(0, 1, 8, 8'h42);
    expect_rd("R6 mux strobe style", 0, 1, 8, 8'h42);
    expect_rd("R6 mux status", 0, 1, 2, 8'hA5);
    expect_rd("R3 earlier data kept", 1, 1, 21, sh[21]);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule